// File: doc/BRIEF.md
# Power-Good Strap Sampling Sequencer

This block controls start-up for a clock generator. After reset it passes through an idle off state and then waits for the active-low power-good input. That input must stay low without a break for a programmable settling interval. This masks the glitches a supply produces while it ramps. Once the interval completes, the block spends one cycle capturing the mode/frequency select straps and the output-current multiplier strap into holding registers. The held values drive mode selection downstream and can be read back as status.

After capture, the block raises the oscillator/VCO enable. It raises the clock output enable a programmable number of cycles later, which models PLL lock time. From then on the block is frozen: power-good is honoured only once. Further activity on power-good or on the strap pins is ignored until the next reset.

The block reports its phase on a two-bit state indicator:

| Code | Phase |
|------|-------|
| 0 | off |
| 1 | waiting for power-good |
| 2 | sampling the straps |
| 3 | running |

Top module: `pwrgd_strap_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, the state indicator reads 0. VCO enable and output enable are low, and both held strap registers read zero.
- R2: The state moves from 0 to 1 on the first clock edge after reset is released, whatever the power-good level.
- R3: In state 1 the state changes to 2 on the clock edge that completes SETTLE_CYC consecutive edges with power-good low. Before that edge the state stays 1.
- R4: A high level on power-good during state 1 restarts the settling count. The state stays 1 and VCO enable stays low until a new unbroken low run of SETTLE_CYC edges completes.
- R5: State 2 lasts exactly one cycle. The held straps take the strap values present during that cycle, not values from earlier in state 1, and are visible once state 3 begins.
- R6: VCO enable is high exactly while the state is 3, so it rises one cycle after state 2.
- R7: Output enable rises exactly LOCK_CYC cycles after VCO enable rises. With LOCK_CYC equal to 0 it rises together with VCO enable.
- R8: Once state 3 is reached, power-good and the strap inputs have no effect. The state stays 3, both enables stay high, and the held straps keep their captured values.
- R9: A reset issued while running returns the block to state 0 and re-arms it. A new power-good qualification then captures the strap values present at that later sampling cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrgd_n | input | 1 | Active-low power-good level |
| strap_sel | input | SEL_W | Mode/frequency select strap pins |
| strap_mult | input | 1 | Output-current multiplier strap pin |
| sel_held | output | SEL_W | Captured select straps |
| mult_held | output | 1 | Captured multiplier strap |
| vco_en | output | 1 | Oscillator/VCO enable |
| out_en | output | 1 | Clock output enable |
| seq_state | output | 2 | Sequencer phase code (0 off, 1 wait, 2 sample, 3 run) |

## Verification
The first power-good pattern is a low run one cycle short of the settling interval, followed by a single high cycle. This separates a counter that restarts on a glitch from one that only pauses or that fires early. An unbroken low run then checks the exact edge of the move to state 2.

The strap pins are driven with complemented values until the sampling cycle and complemented again right after it. This tells capture in state 2 apart from capture one cycle early or late.

After lock, power-good is toggled and the straps are swapped to show the one-shot freeze. A reset in the middle of a run followed by a second sequence with different straps shows that the block re-arms.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
   typedef enum logic [1:0] {
      PGS_OFF    = 2'd0,
      PGS_WAIT   = 2'd1,
      PGS_SAMPLE = 2'd2,
      PGS_RUN    = 2'd3
   } pgs_state_e;
endpackage

// File: rtl/pgs_delay_cnt.sv
module pgs_delay_cnt #(
   parameter int LIMIT = 16,
   localparam int CW   = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic at_last,
   output logic reached
);
   localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
   localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   // Counts while run is high, saturates at LIMIT, and clears when run drops.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run)
         cnt_q <= '0;
      else if (cnt_q != LIM_V)
         cnt_q <= cnt_q + 1'b1;
   end

   assign at_last = run && (cnt_q == LAST_V);
   assign reached = run && (cnt_q == LIM_V);
endmodule

// File: rtl/pgs_fsm.sv
module pgs_fsm
   import pgs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwrgd_n,
   input  logic       settle_last,
   output logic       settle_run,
   output logic       capture,
   output logic       running,
   output pgs_state_e state
);
   pgs_state_e state_q, state_d;

   // Settling counts only while waiting and power-good is low.
   assign settle_run = (state_q == PGS_WAIT) && !pwrgd_n;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PGS_OFF:    state_d = PGS_WAIT;
         PGS_WAIT:   if (settle_run && settle_last) state_d = PGS_SAMPLE;
         PGS_SAMPLE: state_d = PGS_RUN;
         PGS_RUN:    state_d = PGS_RUN;   // one-shot: only reset leaves
         default:    state_d = PGS_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PGS_OFF;
      else        state_q <= state_d;
   end

   assign capture = (state_q == PGS_SAMPLE);
   assign running = (state_q == PGS_RUN);
   assign state   = state_q;
endmodule

// File: rtl/pgs_strap_hold.sv
module pgs_strap_hold #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [SEL_W-1:0] sel_in,
   input  logic             mult_in,
   output logic [SEL_W-1:0] sel_q,
   output logic             mult_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         mult_q <= 1'b0;
      end else if (capture) begin
         sel_q  <= sel_in;
         mult_q <= mult_in;
      end
   end
endmodule

// File: rtl/pwrgd_strap_seq.sv
module pwrgd_strap_seq
   import pgs_pkg::*;
#(
   parameter int SEL_W      = 3,
   parameter int SETTLE_CYC = 16,
   parameter int LOCK_CYC   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwrgd_n,
   input  logic [SEL_W-1:0] strap_sel,
   input  logic             strap_mult,
   output logic [SEL_W-1:0] sel_held,
   output logic             mult_held,
   output logic             vco_en,
   output logic             out_en,
   output logic [1:0]       seq_state
);
   if (SEL_W < 1) begin : g_bad_sel
      $error("SEL_W must be at least 1");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("SETTLE_CYC must be at least 1");
   end
   if (LOCK_CYC < 0) begin : g_bad_lock
      $error("LOCK_CYC must not be negative");
   end

   pgs_state_e state;
   logic       settle_run, settle_last, settle_full;
   logic       capture, running;

   pgs_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .pwrgd_n     (pwrgd_n),
      .settle_last (settle_last),
      .settle_run  (settle_run),
      .capture     (capture),
      .running     (running),
      .state       (state)
   );

   pgs_delay_cnt #(.LIMIT(SETTLE_CYC)) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (settle_run),
      .at_last (settle_last),
      .reached (settle_full)
   );

   pgs_strap_hold #(.SEL_W(SEL_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .sel_in  (strap_sel),
      .mult_in (strap_mult),
      .sel_q   (sel_held),
      .mult_q  (mult_held)
   );

   assign vco_en    = running;
   assign seq_state = state;

   if (LOCK_CYC == 0) begin : g_no_lock
      assign out_en = running;
   end else begin : g_lock
      logic lock_last;
      pgs_delay_cnt #(.LIMIT(LOCK_CYC)) u_lock (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (running),
         .at_last (lock_last),
         .reached (out_en)
      );
   end
endmodule

// File: rtl/pwrgd_strap_seq_chk.sv
module pwrgd_strap_seq_chk #(
   parameter int SEL_W    = 3,
   parameter int LOCK_CYC = 6,
   localparam int LW      = $clog2(LOCK_CYC + 2)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwrgd_n,
   input logic [SEL_W-1:0] sel_held,
   input logic             mult_held,
   input logic             vco_en,
   input logic             out_en,
   input logic [1:0]       seq_state
);
   localparam logic [LW-1:0] LOCK_V = LW'(LOCK_CYC);

   // Independent count of cycles spent with the VCO enabled.
   logic [LW-1:0] on_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    on_cnt <= '0;
      else if (!vco_en)              on_cnt <= '0;
      else if (on_cnt != LOCK_V)     on_cnt <= on_cnt + 1'b1;
   end

   assert_off_to_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
      seq_state == 2'd0 |=> seq_state == 2'd1);

   assert_wait_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      seq_state == 2'd1 |=> (seq_state == 2'd1 || seq_state == 2'd2));

   assert_glitch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == 2'd1 && pwrgd_n) |=> seq_state == 2'd1);

   assert_one_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
      seq_state == 2'd2 |=> seq_state == 2'd3);

   assert_vco_after_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vco_en) |-> $past(seq_state) == 2'd2);

   assert_lock_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (vco_en && on_cnt != LOCK_V) |-> !out_en);

   assert_lock_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (vco_en && on_cnt == LOCK_V) |-> out_en);

   assert_out_needs_vco_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_en |-> vco_en);

   assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      seq_state == 2'd3 |=> (seq_state == 2'd3 && $stable(sel_held) && $stable(mult_held)));
endmodule

bind pwrgd_strap_seq pwrgd_strap_seq_chk #(.SEL_W(SEL_W), .LOCK_CYC(LOCK_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwrgd_n   (pwrgd_n),
   .sel_held  (sel_held),
   .mult_held (mult_held),
   .vco_en    (vco_en),
   .out_en    (out_en),
   .seq_state (seq_state)
);

// File: tb/pwrgd_strap_seq_bench.sv
module pwrgd_strap_seq_bench;
   localparam int SETTLE = 16;
   localparam int LOCK   = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwrgd_n = 1'b1;
   logic [2:0] strap_sel = 3'd0;
   logic       strap_mult = 1'b0;
   logic [2:0] sel_held;
   logic       mult_held, vco_en, out_en;
   logic [1:0] seq_state;

   int total = 0;
   int bad = 0;
   logic [3:0] exp_q[$];

   always #10 clk = ~clk;

   pwrgd_strap_seq #(.SEL_W(3), .SETTLE_CYC(SETTLE), .LOCK_CYC(LOCK)) u_pwrgd_strap_seq (
      .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .strap_sel(strap_sel),
      .strap_mult(strap_mult), .sel_held(sel_held), .mult_held(mult_held),
      .vco_en(vco_en), .out_en(out_en), .seq_state(seq_state)
   );

   task automatic chk_eq(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Monitor: on each VCO enable rise, pop the expected straps and time the lock.
   logic prev_vco = 1'b0;
   bit   tracking = 0;
   int   lk = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         prev_vco = 1'b0;
         tracking = 0;
      end else begin
         if (vco_en && !prev_vco) begin
            if (exp_q.size() == 0) chk_eq("R5 unexpected capture", 1, 0);
            else begin
               logic [3:0] e;
               e = exp_q.pop_front();
               chk_eq("R5 held select", int'(sel_held), int'(e[2:0]));
               chk_eq("R5 held multiplier", int'(mult_held), int'(e[3]));
            end
            lk = 0;
            if (LOCK == 0) chk_eq("R7 out_en with vco", int'(out_en), 1);
            else begin
               chk_eq("R7 out_en early", int'(out_en), 0);
               tracking = 1;
            end
         end else if (tracking) begin
            lk++;
            if (out_en) begin
               chk_eq("R7 lock delay", lk, LOCK);
               tracking = 0;
            end else if (lk > LOCK) begin
               chk_eq("R7 lock delay", lk, LOCK);
               tracking = 0;
            end
         end
         prev_vco = vco_en;
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      pwrgd_n = 1'b1;
      repeat (2) @(negedge clk);
      chk_eq("R1 state in reset", int'(seq_state), 0);
      chk_eq("R1 vco_en in reset", int'(vco_en), 0);
      chk_eq("R1 out_en in reset", int'(out_en), 0);
      chk_eq("R1 held straps in reset", int'({mult_held, sel_held}), 0);
      rst_n = 1'b1;
      chk_eq("R1 state after release", int'(seq_state), 0);
      @(negedge clk);
      chk_eq("R2 state one edge after release", int'(seq_state), 1);
   endtask

   task automatic glitch_test();
      strap_sel = 3'b011;
      strap_mult = 1'b1;
      pwrgd_n = 1'b0;
      for (int i = 1; i < SETTLE; i++) @(negedge clk);
      pwrgd_n = 1'b1;
      @(negedge clk);
      chk_eq("R4 state after glitch", int'(seq_state), 1);
      chk_eq("R4 vco_en after glitch", int'(vco_en), 0);
      pwrgd_n = 1'b0;
      for (int i = 1; i < SETTLE; i++) begin
         @(negedge clk);
         if (seq_state != 2'd1) chk_eq("R4 count restarted", int'(seq_state), 1);
      end
      pwrgd_n = 1'b1;
      @(negedge clk);
      chk_eq("R4 still waiting after second short run", int'(seq_state), 1);
   endtask

   task automatic run_seq(input logic [2:0] s, input logic m);
      strap_sel = ~s;
      strap_mult = ~m;
      pwrgd_n = 1'b0;
      for (int i = 1; i < SETTLE; i++) begin
         @(negedge clk);
         if (seq_state != 2'd1) chk_eq("R3 left wait too early", int'(seq_state), 1);
      end
      chk_eq("R3 still waiting one edge before", int'(seq_state), 1);
      @(negedge clk);
      chk_eq("R3 sample state after settle", int'(seq_state), 2);
      chk_eq("R6 vco_en low in sample", int'(vco_en), 0);
      strap_sel = s;
      strap_mult = m;
      exp_q.push_back({m, s});
      @(negedge clk);
      chk_eq("R5 run after one sample cycle", int'(seq_state), 3);
      chk_eq("R6 vco_en high in run", int'(vco_en), 1);
      strap_sel = ~s;
      strap_mult = ~m;
   endtask

   initial begin
      do_reset();
      glitch_test();
      run_seq(3'b101, 1'b1);
      repeat (LOCK + 2) @(negedge clk);
      chk_eq("R7 out_en after lock", int'(out_en), 1);

      // R8: power-good and strap activity after lock must change nothing
      for (int i = 0; i < 12; i++) begin
         pwrgd_n = i[0];
         strap_sel = 3'(i);
         strap_mult = i[1];
         @(negedge clk);
         if (seq_state != 2'd3 || !vco_en || !out_en || sel_held != 3'b101 || !mult_held)
            chk_eq("R8 frozen after run", int'({seq_state, vco_en, out_en, mult_held, sel_held}),
                   int'({2'd3, 1'b1, 1'b1, 1'b1, 3'b101}));
      end
      chk_eq("R8 held select unchanged", int'(sel_held), 5);
      chk_eq("R8 state still run", int'(seq_state), 3);

      // R9: reset while running re-arms with new straps
      do_reset();
      chk_eq("R9 exp queue drained", exp_q.size(), 0);
      run_seq(3'b010, 1'b0);
      repeat (LOCK + 2) @(negedge clk);
      chk_eq("R9 rerun held select", int'(sel_held), 2);
      chk_eq("R9 rerun held multiplier", int'(mult_held), 0);
      chk_eq("R9 rerun out_en", int'(out_en), 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule